// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement and Precise Faults

This block sits between instruction issue and the architectural register file of an out-of-order core. Issue claims a slot in a circular buffer for each instruction in program order and receives that slot's tag. Execution units later report results against tags in any order, each with an optional fault marker. The buffer then hands results to the register file strictly oldest-first, one per cycle, and only once the oldest instruction has finished.

A fault stays inside its entry until that entry becomes the oldest in the buffer. At that point nothing is written for it. Every entry is discarded, one exception pulse is raised with the faulting PC, and the pointers return to slot 0. Architectural state therefore only ever reflects instructions older than the fault. Operand lookups search the buffer for the youngest in-flight writer of a register. They report that entry's tag, whether its result is still pending, and its value. When no entry writes the register, they return the register file content.

Allocation is a valid/ready stream: an instruction is taken on a cycle where both are high, and ready drops while the buffer is full or while a fault is being taken. Completions carry no ready. They are always taken, and any completion that names a slot with no live entry is dropped. Commit, exception and lookup signals are plain combinational outputs derived from the current buffer state.

Top module: `precise_rob`

## Requirements
- R1: An allocation is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_tag` shows the slot that allocation receives. After reset, and after every flush, tags are handed out as 0, 1, 2, ... and wrap modulo 8.
- R2: `alloc_ready` is low whenever all 8 slots hold live entries. It is high again on the first cycle with a free slot and no fault being taken.
- R3: A completion on `cmpl_valid` records its result and fault marker in the slot named by `cmpl_tag`, whatever the order of completions. A completion that names a slot with no live entry changes nothing.
- R4: Only the oldest live entry retires, and only once it has completed without a fault. At most one entry retires per cycle. On that cycle `commit_valid` is high with the entry's destination and result, and the register file holds that value from the next cycle.
- R5: `lookup_found` is high when a live entry writes `lookup_reg`. If several do, `lookup_tag` is the youngest of them. `lookup_pending` is high while that entry has not completed, and `lookup_value` carries its result once it has. With no match, `lookup_value` is the register file content.
- R6: A fault becomes visible only when its entry is the oldest and has completed. `exc_valid` is then high for exactly one cycle with `exc_pc` equal to that entry's PC, `commit_valid` stays low, and the register file is not written.
- R7: On the cycle `exc_valid` is high, all entries are discarded. Younger results, whether already completed or not, never reach the register file, and the next allocation receives tag 0.
- R8: While `exc_valid` is high, `alloc_ready` is low, and completions arriving in that cycle are dropped.
- R9: After reset the buffer is empty. `alloc_ready` is high, `commit_valid` and `exc_valid` are low, and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Issue presents an instruction |
| alloc_ready | output | 1 | Buffer can take an instruction this cycle |
| alloc_dest | input | 4 | Destination register of the incoming instruction |
| alloc_pc | input | 32 | PC of the incoming instruction |
| alloc_tag | output | 3 | Slot the incoming instruction receives |
| cmpl_valid | input | 1 | An execution unit reports a finished instruction |
| cmpl_tag | input | 3 | Slot of the finished instruction |
| cmpl_result | input | 32 | Result value |
| cmpl_fault | input | 1 | Instruction faulted |
| lookup_reg | input | 4 | Register whose newest value is requested |
| lookup_found | output | 1 | A live entry writes that register |
| lookup_tag | output | 3 | Slot of the youngest such entry |
| lookup_pending | output | 1 | That entry has not completed |
| lookup_value | output | 32 | Buffered result, or register file content if no match |
| commit_valid | output | 1 | Oldest entry retires to the register file |
| commit_reg | output | 4 | Register written by the retiring entry |
| commit_value | output | 32 | Value written by the retiring entry |
| exc_valid | output | 1 | One-cycle precise exception pulse |
| exc_pc | output | 32 | PC of the faulting instruction |

## Verification
The bench targets younger instructions that finish and fault before older ones. A design that raised faults at completion, or that retired past an unfinished head, would show an exception or commit sooner than the model and write state that should never land. It keeps several in-flight writers of a few registers so that lookups have multiple matches. A search that picked the oldest match, or that ignored pointer wrap, would return a stale tag or value. The bench also fills the buffer to its limit, sends completions to empty slots, and allocates across flushes. Wrong full detection, acceptance of stray completions, or pointers not returned to slot 0 would each surface as a ready, tag or value mismatch.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Action taken at the head of the buffer in the current cycle.
  typedef enum logic [1:0] {
    RET_IDLE  = 2'd0,
    RET_WRITE = 2'd1,
    RET_TRAP  = 2'd2
  } retire_e;

endpackage

// File: rtl/rob_arch_rf.sv
module rob_arch_rf #(
  parameter int NREGS  = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(NREGS)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data
);

  logic [DATA_W-1:0] regs_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_addr];

  // A retired value must be present in the register file on the next cycle.
  assert_wb_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/rob_youngest_match.sv
module rob_youngest_match #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 4
) (
  input  logic [ENTRIES-1:0]         live_i,
  input  logic [REG_W-1:0]           dest_i [ENTRIES],
  input  logic [$clog2(ENTRIES)-1:0] head_i,
  input  logic [REG_W-1:0]           key_i,
  output logic                       found_o,
  output logic [$clog2(ENTRIES)-1:0] idx_o
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0]   best_age;
  logic [IDX_W-1:0]   age [ENTRIES];
  logic [ENTRIES-1:0] hit;

  // Age is the distance from the head; the largest age is the youngest entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    assign age[g] = IDX_W'(g) - head_i;
    assign hit[g] = live_i[g] && (dest_i[g] == key_i);
  end

  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    best_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i] && (!found_o || age[i] >= best_age)) begin
        found_o  = 1'b1;
        idx_o    = IDX_W'(i);
        best_age = age[i];
      end
    end
  end

  always_comb begin
    if (found_o) begin
      assert_match_sel_R5: assert (live_i[idx_o] && dest_i[idx_o] == key_i);
    end
  end

endmodule

// File: rtl/precise_rob.sv
module precise_rob #(
  parameter int ENTRIES = 8,
  parameter int NREGS   = 16,
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  input  logic [$clog2(NREGS)-1:0]   alloc_dest,
  input  logic [PC_W-1:0]            alloc_pc,
  output logic [$clog2(ENTRIES)-1:0] alloc_tag,
  input  logic                       cmpl_valid,
  input  logic [$clog2(ENTRIES)-1:0] cmpl_tag,
  input  logic [DATA_W-1:0]          cmpl_result,
  input  logic                       cmpl_fault,
  input  logic [$clog2(NREGS)-1:0]   lookup_reg,
  output logic                       lookup_found,
  output logic [$clog2(ENTRIES)-1:0] lookup_tag,
  output logic                       lookup_pending,
  output logic [DATA_W-1:0]          lookup_value,
  output logic                       commit_valid,
  output logic [$clog2(NREGS)-1:0]   commit_reg,
  output logic [DATA_W-1:0]          commit_value,
  output logic                       exc_valid,
  output logic [PC_W-1:0]            exc_pc
);
  import rob_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam int REG_W = $clog2(NREGS);

  // Entry state
  logic [ENTRIES-1:0] ent_valid, ent_done, ent_fault;
  logic [REG_W-1:0]   ent_dest [ENTRIES];
  logic [DATA_W-1:0]  ent_res  [ENTRIES];
  logic [PC_W-1:0]    ent_pc   [ENTRIES];

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  retire_e ret_act;
  logic    alloc_fire, cmpl_hit, do_write, do_trap;

  // Head decision: retire, trap or wait.
  always_comb begin
    ret_act = RET_IDLE;
    if (ent_valid[head_q] && ent_done[head_q]) begin
      ret_act = ent_fault[head_q] ? RET_TRAP : RET_WRITE;
    end
  end

  assign do_write    = (ret_act == RET_WRITE);
  assign do_trap     = (ret_act == RET_TRAP);
  assign alloc_ready = (count_q != CNT_W'(ENTRIES)) && !do_trap;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;
  assign cmpl_hit    = cmpl_valid && ent_valid[cmpl_tag] && !do_trap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_done  <= '0;
      ent_fault <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_dest[i] <= '0;
        ent_res[i]  <= '0;
        ent_pc[i]   <= '0;
      end
    end else if (do_trap) begin
      ent_valid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_fire && tail_q == IDX_W'(i)) begin
          ent_valid[i] <= 1'b1;
          ent_done[i]  <= 1'b0;
          ent_fault[i] <= 1'b0;
          ent_dest[i]  <= alloc_dest;
          ent_pc[i]    <= alloc_pc;
        end else if (do_write && head_q == IDX_W'(i)) begin
          ent_valid[i] <= 1'b0;
        end
        if (cmpl_hit && cmpl_tag == IDX_W'(i)) begin
          ent_done[i]  <= 1'b1;
          ent_fault[i] <= cmpl_fault;
          ent_res[i]   <= cmpl_result;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (do_trap) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_fire) tail_q <= tail_q + IDX_W'(1);
      if (do_write)   head_q <= head_q + IDX_W'(1);
      count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(do_write);
    end
  end

  // Register file and operand bypass
  logic             match_found;
  logic [IDX_W-1:0] match_idx;
  logic [DATA_W-1:0] rf_rd;

  rob_arch_rf #(.NREGS(NREGS), .DATA_W(DATA_W)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (do_write),
    .wr_addr(ent_dest[head_q]),
    .wr_data(ent_res[head_q]),
    .rd_addr(lookup_reg),
    .rd_data(rf_rd)
  );

  rob_youngest_match #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_match (
    .live_i (ent_valid),
    .dest_i (ent_dest),
    .head_i (head_q),
    .key_i  (lookup_reg),
    .found_o(match_found),
    .idx_o  (match_idx)
  );

  assign lookup_found   = match_found;
  assign lookup_tag     = match_idx;
  assign lookup_pending = match_found && !ent_done[match_idx];
  assign lookup_value   = match_found ? ent_res[match_idx] : rf_rd;

  assign commit_valid = do_write;
  assign commit_reg   = ent_dest[head_q];
  assign commit_value = ent_res[head_q];
  assign exc_valid    = do_trap;
  assign exc_pc       = ent_pc[head_q];

  // Checks
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(ENTRIES));

  assert_alloc_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> ent_valid[$past(tail_q)]);

  assert_head_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> (head_q == $past(head_q) + IDX_W'(1)));

  assert_trap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (count_q == '0 && ent_valid == '0 && tail_q == '0));

  assert_trap_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !alloc_ready);

endmodule

// File: tb/precise_rob_tb_top.sv
`timescale 1ns/1ps
module precise_rob_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [3:0]  alloc_dest = '0;
  logic [31:0] alloc_pc = '0;
  logic [2:0]  alloc_tag;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_tag = '0;
  logic [31:0] cmpl_result = '0;
  logic        cmpl_fault = 1'b0;
  logic [3:0]  lookup_reg = '0;
  logic        lookup_found;
  logic [2:0]  lookup_tag;
  logic        lookup_pending;
  logic [31:0] lookup_value;
  logic        commit_valid;
  logic [3:0]  commit_reg;
  logic [31:0] commit_value;
  logic        exc_valid;
  logic [31:0] exc_pc;

  always #5 clk = ~clk;

  precise_rob dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .cmpl_result(cmpl_result), .cmpl_fault(cmpl_fault),
    .lookup_reg(lookup_reg), .lookup_found(lookup_found),
    .lookup_tag(lookup_tag), .lookup_pending(lookup_pending),
    .lookup_value(lookup_value),
    .commit_valid(commit_valid), .commit_reg(commit_reg),
    .commit_value(commit_value),
    .exc_valid(exc_valid), .exc_pc(exc_pc)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference state
  bit        m_v [8];
  bit        m_d [8];
  bit        m_f [8];
  bit [3:0]  m_dst [8];
  bit [31:0] m_res [8];
  bit [31:0] m_pc [8];
  bit [31:0] m_rf [16];
  int        m_h = 0, m_t = 0, m_c = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_trap();
    return m_v[m_h] && m_d[m_h] && m_f[m_h];
  endfunction

  function automatic bit m_write();
    return m_v[m_h] && m_d[m_h] && !m_f[m_h];
  endfunction

  function automatic bit m_ready();
    return (m_c != 8) && !m_trap();
  endfunction

  // Youngest live writer of a register, -1 if none.
  function automatic int m_lookup(input bit [3:0] r);
    int best = -1;
    for (int a = 0; a < 8; a++) begin
      int s = (m_h + a) % 8;
      if (m_v[s] && m_dst[s] == r) best = s;
    end
    return best;
  endfunction

  task automatic compare_outputs();
    int s;
    chk("R2", "alloc_ready", 32'(alloc_ready), 32'(m_ready()));
    if (m_ready()) chk("R1", "alloc_tag", 32'(alloc_tag), 32'(m_t));
    chk("R4", "commit_valid", 32'(commit_valid), 32'(m_write()));
    if (m_write()) begin
      chk("R4", "commit_reg", 32'(commit_reg), 32'(m_dst[m_h]));
      chk("R4", "commit_value", commit_value, m_res[m_h]);
    end
    chk("R6", "exc_valid", 32'(exc_valid), 32'(m_trap()));
    if (m_trap()) chk("R6", "exc_pc", exc_pc, m_pc[m_h]);
    s = m_lookup(lookup_reg);
    chk("R5", "lookup_found", 32'(lookup_found), 32'(s >= 0));
    if (s >= 0) begin
      chk("R5", "lookup_tag", 32'(lookup_tag), 32'(s));
      chk("R5", "lookup_pending", 32'(lookup_pending), 32'(!m_d[s]));
      if (m_d[s]) chk("R5", "lookup_value", lookup_value, m_res[s]);
    end else begin
      chk("R4", "lookup_value_rf", lookup_value, m_rf[lookup_reg]);
    end
  endtask

  task automatic update_model();
    bit fire, wr;
    if (m_trap()) begin
      for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
      m_h = 0; m_t = 0; m_c = 0;
      return;
    end
    fire = alloc_valid && m_ready();
    wr   = m_write();
    if (cmpl_valid && m_v[cmpl_tag]) begin
      m_d[cmpl_tag]   = 1'b1;
      m_f[cmpl_tag]   = cmpl_fault;
      m_res[cmpl_tag] = cmpl_result;
    end
    if (wr) begin
      m_rf[m_dst[m_h]] = m_res[m_h];
      m_v[m_h] = 1'b0;
      m_h = (m_h + 1) % 8;
    end
    if (fire) begin
      m_v[m_t] = 1'b1; m_d[m_t] = 1'b0; m_f[m_t] = 1'b0;
      m_dst[m_t] = alloc_dest; m_pc[m_t] = alloc_pc;
      m_t = (m_t + 1) % 8;
    end
    m_c = m_c + int'(fire) - int'(wr);
  endtask

  // One cycle: drive at the falling edge, compare, advance the model.
  task automatic step(input int alloc_pct, input int cmpl_pct,
                      input int fault_pct, input int stray_pct);
    int pick;
    @(negedge clk);
    alloc_valid = ($urandom % 100) < alloc_pct;
    alloc_dest  = 4'($urandom % 6);
    alloc_pc    = {$urandom, 2'b00} ^ 32'h0000_1000;
    lookup_reg  = 4'($urandom % 7);
    cmpl_valid  = 1'b0;
    cmpl_fault  = 1'b0;
    cmpl_result = $urandom;
    pick = -1;
    if (($urandom % 100) < stray_pct) begin
      for (int i = 0; i < 8; i++) if (!m_v[i] && pick < 0) pick = i;
    end else if (($urandom % 100) < cmpl_pct) begin
      int off = $urandom % 8;
      for (int i = 0; i < 8; i++) begin
        int s = (off + i) % 8;
        if (m_v[s] && !m_d[s] && pick < 0) pick = s;
      end
    end
    if (pick >= 0) begin
      cmpl_valid = 1'b1;
      cmpl_tag   = 3'(pick);
      cmpl_fault = ($urandom % 100) < fault_pct;
    end
    #1;
    compare_outputs();
    update_model();
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_d[i] = 0; m_f[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    chk("R9", "alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R9", "commit_valid", 32'(commit_valid), 32'd0);
    chk("R9", "exc_valid", 32'(exc_valid), 32'd0);
    chk("R9", "alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R9", "lookup_value", lookup_value, 32'd0);
    // R2: fill with no completions until full
    repeat (12) step(100, 0, 0, 0);
    // R3: stray completion targets while full is impossible; with free slots below
    repeat (600) step(60, 50, 0, 10);
    // R6 R7 R8: faults mixed with out-of-order completion
    repeat (2000) step(65, 55, 6, 8);
    // Drain
    repeat (40) step(0, 100, 0, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule